// File: doc/BRIEF.md
# Scrambled 130-Bit Lane Block Transmitter

This block turns a byte stream for a single serial lane into 130-bit blocks. Every block opens with a two-bit sync header that says whether the block carries data or an ordered set. Sixteen byte symbols follow the header. Symbol k starts at unit interval 2 + 8k, so symbol 0 starts at UI 2 and symbol 15 at UI 122. Each symbol goes out least significant bit first.

Symbols of data blocks are XORed with the output of a 23-bit linear feedback shift register. Ordered-set symbols pass through unchanged. The LFSR steps only while it scrambles data bits. When an ordered-set block is marked as an electrical-idle-exit set, the LFSR goes back to its seed.

The upstream side offers one byte per cycle. Each byte comes with a valid bit, a start-of-block marker, and, on the first byte of a block, the block kind and the idle-exit marker. The downstream side gets one registered beat per accepted byte. The sync header travels on separate header outputs in the same beat as symbol 0, so one beat never carries more than one symbol. A serializer placed after the block shifts out the header first and then each symbol from bit 0 upward.

Top module: `lane_block_tx`

## Requirements
- R1: A block is a sync header followed by exactly SYMS (16) symbols. `hdr_vld` is high only in the output beat that carries symbol 0, and `sym_vld` is high in every beat that carries a symbol.
- R2: `hdr_bits[0]` is the first unit interval on the line. A data block sends `hdr_bits` = 2'b10 (UI0 = 0, UI1 = 1). An ordered-set block sends 2'b01.
- R3: A data symbol leaves as `sym_out = sym_in ^ mask`. Bit i of mask is the LFSR output taken at the i-th step for that symbol, with bit 0 first, which matches LSB-first transmission. Each data symbol steps the LFSR 8 times.
- R4: The LFSR is a left-shifting register s[22:0]. Its output bit is s[22] and its feedback bit is s[22]^s[20]^s[17]^s[14]^s[6]^s[1], which is the polynomial x^23+x^21+x^18+x^15+x^7+x^2+1. After reset it holds the seed 23'h1DBFBC.
- R5: Ordered-set symbols leave unchanged. The LFSR does not step for them, for the sync header, or for cycles with `sym_vld_in` low.
- R6: When `sob_in`, `is_os_in` and `eios_in` are all high on an accepted beat, the LFSR reloads the seed, and the next data symbol is scrambled from the seed. `eios_in` has no effect on a data block or on a beat without `sob_in`.
- R7: A valid byte without `sob_in` that arrives when no block is open is ignored. It gives no output beat and does not step the LFSR.
- R8: `sob_in` in the middle of a block starts a new block at symbol 0 with a new header.
- R9: Every accepted byte appears at the outputs one clock later. After reset all valid outputs are low.
- R10: A descrambler with the same polynomial and seed, which reloads on idle-exit sets, recovers every original byte of the data blocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_vld_in | input | 1 | Input byte valid |
| sob_in | input | 1 | First byte of a block |
| is_os_in | input | 1 | Block is an ordered set; sampled with `sob_in` |
| eios_in | input | 1 | Block is an idle-exit ordered set; sampled with `sob_in` |
| sym_in | input | 8 | Input byte |
| sym_vld | output | 1 | Output symbol valid |
| sym_out | output | 8 | Output symbol, scrambled for data blocks |
| hdr_vld | output | 1 | Sync header valid, together with symbol 0 |
| hdr_bits | output | 2 | Sync header, bit 0 sent first |

## Verification
The bench sends all 256 byte values through data blocks. It checks every output symbol against its own bit-serial LFSR, so a reversed bit order or a wrong tap shows up as a mask mismatch. Ordered-set blocks are interleaved with the data blocks. A design that stepped the LFSR during them would scramble the following data block with the wrong mask. Idle-exit blocks are tested together with idle-exit markers placed on data blocks, so a missing reload and a spurious reload both show up. Input gaps, stray bytes after a block closes, and restarts in the middle of a block are also covered; a design that miscounted would open the wrong headers, emit phantom beats or step the LFSR at the wrong time.

// File: rtl/lbt_pkg.sv
package lbt_pkg;
  localparam int LFSR_W = 23;
  localparam int SYM_W  = 8;
  localparam logic [LFSR_W-1:0] SEED = 23'h1DBFBC;
  localparam logic [1:0] HDR_DATA = 2'b10;
  localparam logic [1:0] HDR_OS   = 2'b01;

  typedef struct packed {
    logic [LFSR_W-1:0] next;
    logic [SYM_W-1:0]  mask;
  } scr_step_t;

  // Steps the LFSR once per symbol bit; mask bit i is the output bit of step i.
  function automatic scr_step_t scr_step(input logic [LFSR_W-1:0] s);
    scr_step_t r;
    logic [LFSR_W-1:0] t;
    t = s;
    r.mask = '0;
    for (int i = 0; i < SYM_W; i++) begin
      r.mask[i] = t[22];
      t = {t[21:0], t[22] ^ t[20] ^ t[17] ^ t[14] ^ t[6] ^ t[1]};
    end
    r.next = t;
    return r;
  endfunction
endpackage

// File: rtl/lbt_framer.sv
module lbt_framer #(
  parameter int SYMS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic vld_in,
  input  logic sob_in,
  input  logic is_os_in,
  output logic beat_ok,
  output logic beat_os,
  output logic beat_first
);
  localparam int IW = $clog2(SYMS) + 1;

  logic          open_q;
  logic          os_q;
  logic [IW-1:0] idx_q;
  logic [IW-1:0] cur_idx;
  logic          last_sym;

  assign beat_ok    = vld_in && (sob_in || open_q);
  assign beat_first = beat_ok && sob_in;
  assign cur_idx    = sob_in ? '0 : idx_q;
  assign beat_os    = sob_in ? is_os_in : os_q;
  assign last_sym   = (cur_idx == IW'(SYMS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      os_q   <= 1'b0;
      idx_q  <= '0;
    end else if (beat_ok) begin
      open_q <= !last_sym;
      os_q   <= beat_os;
      idx_q  <= cur_idx + 1'b1;
    end
  end

  a_r1_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    open_q |-> (idx_q < IW'(SYMS)));
  a_r1_block_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && last_sym) |=> !open_q);
endmodule

// File: rtl/lbt_scrambler.sv
module lbt_scrambler
  import lbt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  input  logic             reload,
  output logic [SYM_W-1:0] mask
);
  logic [LFSR_W-1:0] state_q;
  scr_step_t         step;

  assign step = scr_step(state_q);
  assign mask = step.mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= SEED;
    else if (reload)  state_q <= SEED;
    else if (advance) state_q <= step.next;
  end

  a_r4_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
    state_q != '0);
  a_r6_reload_seed: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> state_q == SEED);
  a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!advance && !reload) |=> $stable(state_q));
endmodule

// File: rtl/lane_block_tx.sv
module lane_block_tx
  import lbt_pkg::*;
#(
  parameter int SYMS = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sym_vld_in,
  input  logic             sob_in,
  input  logic             is_os_in,
  input  logic             eios_in,
  input  logic [SYM_W-1:0] sym_in,
  output logic             sym_vld,
  output logic [SYM_W-1:0] sym_out,
  output logic             hdr_vld,
  output logic [1:0]       hdr_bits
);
  logic             beat_ok, beat_os, beat_first;
  logic             scr_adv, scr_reload;
  logic [SYM_W-1:0] scr_mask;

  lbt_framer #(.SYMS(SYMS)) i_framer (
    .clk(clk), .rst_n(rst_n), .vld_in(sym_vld_in), .sob_in(sob_in),
    .is_os_in(is_os_in), .beat_ok(beat_ok), .beat_os(beat_os),
    .beat_first(beat_first)
  );

  assign scr_adv    = beat_ok && !beat_os;
  assign scr_reload = beat_first && is_os_in && eios_in;

  lbt_scrambler i_scr (
    .clk(clk), .rst_n(rst_n), .advance(scr_adv), .reload(scr_reload),
    .mask(scr_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_vld  <= 1'b0;
      sym_out  <= '0;
      hdr_vld  <= 1'b0;
      hdr_bits <= HDR_DATA;
    end else begin
      sym_vld <= beat_ok;
      hdr_vld <= beat_first;
      if (beat_ok)    sym_out  <= scr_adv ? (sym_in ^ scr_mask) : sym_in;
      if (beat_first) hdr_bits <= is_os_in ? HDR_OS : HDR_DATA;
    end
  end

  a_r1_hdr_with_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld |-> sym_vld);
  a_r2_legal_header: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_vld |-> (hdr_bits == HDR_DATA || hdr_bits == HDR_OS));
  a_r5_os_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_ok && beat_os) |=> sym_out == $past(sym_in));
  a_r7_stray_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_vld_in && !beat_ok) |=> !sym_vld);
endmodule

// File: tb/test_lane_block_tx.sv
module test_lane_block_tx;
  localparam logic [22:0] SEED_T = 23'h1DBFBC;
  localparam logic [22:0] TAPS   = 23'h524042;

  logic clk = 1'b0, rst_n = 1'b0;
  logic vi = 1'b0, sob = 1'b0, isos = 1'b0, eios = 1'b0;
  logic [7:0] din = '0;
  logic sym_vld, hdr_vld;
  logic [7:0] sym_out;
  logic [1:0] hdr_bits;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [22:0] tx_s, rx_s;
  bit m_open, m_os;
  int m_idx;

  always #10 clk = ~clk;

  lane_block_tx i_lane_block_tx (
    .clk(clk), .rst_n(rst_n), .sym_vld_in(vi), .sob_in(sob), .is_os_in(isos),
    .eios_in(eios), .sym_in(din), .sym_vld(sym_vld), .sym_out(sym_out),
    .hdr_vld(hdr_vld), .hdr_bits(hdr_bits)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Bit-serial reference: output the MSB, feedback is the parity of the tapped bits.
  task automatic ref_byte(inout logic [22:0] s, output logic [7:0] m);
    for (int b = 0; b < 8; b++) begin
      m[b] = s[22];
      s = {s[21:0], ^(s & TAPS)};
    end
  endtask

  task automatic beat(input bit v, input bit so, input bit os, input bit ei,
                      input logic [7:0] d, input string tag);
    bit acc, cos;
    int cidx;
    logic [7:0] m, rm, exp_sym;
    vi = v; sob = so; isos = os; eios = ei; din = d;
    acc  = v && (so || m_open);
    cidx = so ? 0 : m_idx;
    cos  = so ? os : m_os;
    exp_sym = d;
    if (acc && !cos) begin
      ref_byte(tx_s, m);
      exp_sym = d ^ m;
    end
    if (acc && so && os && ei) tx_s = SEED_T;
    if (acc) begin
      m_open = (cidx != 15);
      m_idx  = cidx + 1;
      m_os   = cos;
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " R9 valid"}, sym_vld, acc);
    chk({tag, " R1 hdr_vld"}, hdr_vld, acc && so);
    if (acc) begin
      chk({tag, " R3 symbol"}, sym_out, exp_sym);
      if (so) chk({tag, " R2 header"}, hdr_bits, os ? 2'b01 : 2'b10);
      if (!cos) begin
        ref_byte(rx_s, rm);
        chk({tag, " R10 descramble"}, sym_out ^ rm, d);
      end
      if (so && os && ei) rx_s = SEED_T;
    end
  endtask

  task automatic block(input bit os, input bit ei, input int base, input string tag);
    for (int k = 0; k < 16; k++)
      beat(1'b1, k == 0, os, ei, 8'((base + k * 7) & 8'hFF), tag);
  endtask

  initial begin
    tx_s = SEED_T; rx_s = SEED_T;
    m_open = 0; m_os = 0; m_idx = 0;
    repeat (3) @(negedge clk);
    chk("R9 reset sym_vld", sym_vld, 0);
    chk("R9 reset hdr_vld", hdr_vld, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R7: stray byte with no block open
    beat(1'b1, 1'b0, 1'b0, 1'b0, 8'hA5, "R7 stray");
    // R3/R4/R10: every byte value through data blocks from the seed
    for (int b = 0; b < 16; b++)
      for (int k = 0; k < 16; k++)
        beat(1'b1, k == 0, 1'b0, 1'b0, 8'(b * 16 + k), "R3 sweep");
    // R5: ordered set between data blocks, LFSR must hold
    block(1'b1, 1'b0, 8'h3C, "R5 os");
    block(1'b0, 1'b0, 8'h11, "R5 after os");
    // R6: idle-exit marker on a data block has no effect
    block(1'b0, 1'b1, 8'h5A, "R6 eios on data");
    // R6: idle-exit ordered set reloads the seed
    block(1'b1, 1'b1, 8'h00, "R6 eios");
    block(1'b0, 1'b0, 8'h00, "R6 after eios");
    // R5: gaps mid-block do not step the LFSR
    for (int k = 0; k < 16; k++) begin
      beat(1'b1, k == 0, 1'b0, 1'b0, 8'(k * 13), "R5 gap");
      beat(1'b0, 1'b0, 1'b0, 1'b0, 8'hFF, "R5 gap idle");
    end
    // R7: stray byte after block closed
    beat(1'b1, 1'b0, 1'b0, 1'b0, 8'h77, "R7 after close");
    // R8: restart mid-block
    for (int k = 0; k < 5; k++) beat(1'b1, k == 0, 1'b0, 1'b0, 8'(k), "R8 partial");
    block(1'b1, 1'b0, 8'h42, "R8 restart os");
    block(1'b0, 1'b0, 8'h99, "R8 data");
    // R6: eios marker on a non-first beat is ignored
    for (int k = 0; k < 16; k++) beat(1'b1, k == 0, 1'b1, k == 3, 8'(k), "R6 late marker");
    block(1'b0, 1'b0, 8'hC3, "R6 no reload");
    beat(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R9 idle");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule